// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

This combinational unit sits beside the integer ALU of a 32-bit RISC-V core and evaluates the bit-manipulation operations that a compiler emits when it targets the basic bit-manipulation extension. These are the three rotates, the halfword zero-extend, the byte and halfword sign-extends, the three bit counts, the byte reverse and the per-byte OR-combine. The decode stage supplies a 4-bit operation select, two 32-bit operands and the 5-bit immediate from the instruction word. The result is ready in the same cycle.

The unit raises an illegal flag for any select code it does not implement, so that the core can take an illegal-instruction trap in place of producing a wrong result. Unary operations read only the first operand. The rotate-by-immediate operation takes its amount from the immediate field and does not use the second operand.

Top module: `bitmanip_unit`

## Requirements
- R1: Select code 0 rotates `src_a` left and code 1 rotates it right, by `src_b[4:0]`. Bits 31:5 of `src_b` have no effect, and an amount of 0 returns `src_a` unchanged.
- R2: Select code 2 rotates `src_a` right by `shamt_imm`, and `src_b` has no effect on the result.
- R3: Select code 3 returns `{16'h0, src_a[15:0]}`.
- R4: Select code 4 fills bits 31:8 with `src_a[7]` and keeps bits 7:0. Select code 5 fills bits 31:16 with `src_a[15]` and keeps bits 15:0.
- R5: Select code 6 returns the number of leading zero bits of `src_a`, and select code 7 returns the number of trailing zero bits. Both return 32 for an all-zero operand.
- R6: Select code 8 returns the number of set bits in `src_a`, so an all-ones operand gives 32.
- R7: Select code 9 returns the four bytes of `src_a` in reverse order, so byte 0 moves to bits 31:24.
- R8: Select code 10 makes each result byte 8'hFF if the matching byte of `src_a` has any bit set, and 8'h00 if it does not.
- R9: Select codes 11 to 15 drive `op_illegal` high and `result` to zero. Codes 0 to 10 drive `op_illegal` low.
- R10: For the unary codes 3 to 10, `src_b` and `shamt_imm` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Decoded operation select |
| src_a | input | 32 | First operand, the value that is operated on |
| src_b | input | 32 | Second operand, whose low 5 bits give the register rotate amount |
| shamt_imm | input | 5 | Immediate rotate amount |
| result | output | 32 | Operation result |
| op_illegal | output | 1 | High when the select code is not supported |

## Verification
The embedded checks are immediate assertions on the combinational outputs. They assume that every input is at a known 0 or 1 level whenever they evaluate, because an unknown select would make the case fall through to the illegal branch. The bench drives only fully defined values. It changes the inputs away from the clock edge and samples them once they have settled. It covers every select code, every rotate amount and every single-bit position. It also sets high garbage bits in the operands that each operation should ignore, so those bits are shown to have no effect.

// File: rtl/bitmanip_unit.sv
module bitmanip_unit #(
  parameter int XLEN = 32,
  parameter int OPW  = 4
) (
  input  logic [OPW-1:0]          op_sel,
  input  logic [XLEN-1:0]         src_a,
  input  logic [XLEN-1:0]         src_b,
  input  logic [$clog2(XLEN)-1:0] shamt_imm,
  output logic [XLEN-1:0]         result,
  output logic                    op_illegal
);
  localparam int SHW    = $clog2(XLEN);
  localparam int NBYTES = XLEN / 8;

  localparam logic [OPW-1:0] OP_ROL  = 4'd0;
  localparam logic [OPW-1:0] OP_ROR  = 4'd1;
  localparam logic [OPW-1:0] OP_RORI = 4'd2;
  localparam logic [OPW-1:0] OP_ZXH  = 4'd3;
  localparam logic [OPW-1:0] OP_SXB  = 4'd4;
  localparam logic [OPW-1:0] OP_SXH  = 4'd5;
  localparam logic [OPW-1:0] OP_CLZ  = 4'd6;
  localparam logic [OPW-1:0] OP_CTZ  = 4'd7;
  localparam logic [OPW-1:0] OP_CPOP = 4'd8;
  localparam logic [OPW-1:0] OP_REV8 = 4'd9;
  localparam logic [OPW-1:0] OP_ORCB = 4'd10;

  logic [SHW-1:0]  reg_amt, rot_amt;
  logic [SHW:0]    back_amt;
  logic [XLEN-1:0] rot_l, rot_r, rev_bytes, orc_bytes;
  logic [SHW:0]    lead_z, trail_z, ones;
  logic            rot_left;

  assign reg_amt  = src_b[SHW-1:0];
  assign rot_amt  = (op_sel == OP_RORI) ? shamt_imm : reg_amt;
  assign rot_left = (op_sel == OP_ROL);
  assign back_amt = (SHW+1)'(XLEN) - {1'b0, rot_amt};
  assign rot_l    = (src_a << rot_amt) | (src_a >> back_amt);
  assign rot_r    = (src_a >> rot_amt) | (src_a << back_amt);

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign rev_bytes[8*g +: 8] = src_a[8*(NBYTES-1-g) +: 8];
    assign orc_bytes[8*g +: 8] = {8{|src_a[8*g +: 8]}};
  end

  always_comb begin
    logic seen;
    lead_z = '0;
    seen   = 1'b0;
    for (int i = XLEN-1; i >= 0; i--) begin
      if (src_a[i]) seen = 1'b1;
      if (!seen) lead_z = lead_z + 1'b1;
    end
  end

  always_comb begin
    logic seen;
    trail_z = '0;
    seen    = 1'b0;
    for (int i = 0; i < XLEN; i++) begin
      if (src_a[i]) seen = 1'b1;
      if (!seen) trail_z = trail_z + 1'b1;
    end
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < XLEN; i++) ones = ones + {{SHW{1'b0}}, src_a[i]};
  end

  always_comb begin
    op_illegal = 1'b0;
    case (op_sel)
      OP_ROL:          result = rot_l;
      OP_ROR, OP_RORI: result = rot_r;
      OP_ZXH:          result = {{(XLEN-16){1'b0}}, src_a[15:0]};
      OP_SXB:          result = {{(XLEN-8){src_a[7]}}, src_a[7:0]};
      OP_SXH:          result = {{(XLEN-16){src_a[15]}}, src_a[15:0]};
      OP_CLZ:          result = XLEN'(lead_z);
      OP_CTZ:          result = XLEN'(trail_z);
      OP_CPOP:         result = XLEN'(ones);
      OP_REV8:         result = rev_bytes;
      OP_ORCB:         result = orc_bytes;
      default: begin
        result     = '0;
        op_illegal = 1'b1;
      end
    endcase
  end

  always_comb begin
    if (op_illegal)
      assert_illegal_zero_R9: assert (result == '0 && op_sel > OP_ORCB);
    if (op_sel <= OP_RORI)
      assert_rotate_keeps_ones_R1: assert ($countones(result) == $countones(src_a));
    if (op_sel == OP_ROL)
      assert_rol_undo_R1: assert (((result >> rot_amt) | (result << back_amt)) == src_a);
    if (op_sel == OP_SXB)
      assert_sext_fill_R4: assert (result[XLEN-1:8] == {(XLEN-8){result[7]}});
    if (op_sel == OP_CLZ || op_sel == OP_CTZ || op_sel == OP_CPOP)
      assert_count_range_R5: assert (result <= XLEN);
    if (op_sel == OP_REV8)
      assert_rev_keeps_ones_R7: assert ($countones(result) == $countones(src_a));
    if (op_sel == OP_ORCB)
      for (int k = 0; k < NBYTES; k++)
        assert_orc_byte_R8: assert (result[8*k +: 8] == 8'h00 || result[8*k +: 8] == 8'hFF);
  end
endmodule

// File: tb/bitmanip_unit_tb.sv
module bitmanip_unit_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [3:0]  op_sel;
  logic [31:0] src_a, src_b;
  logic [4:0]  shamt_imm;
  logic [31:0] result;
  logic        op_illegal;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  bitmanip_unit dut_i (
    .op_sel(op_sel), .src_a(src_a), .src_b(src_b), .shamt_imm(shamt_imm),
    .result(result), .op_illegal(op_illegal)
  );

  function automatic logic [31:0] m_rol(logic [31:0] a, int n);
    logic [63:0] t;
    t = {a, a} << n;
    return t[63:32];
  endfunction

  function automatic logic [31:0] m_ror(logic [31:0] a, int n);
    logic [63:0] t;
    t = {a, a} >> n;
    return t[31:0];
  endfunction

  function automatic int m_clz(logic [31:0] a);
    for (int i = 31; i >= 0; i--) if (a[i]) return 31 - i;
    return 32;
  endfunction

  function automatic int m_ctz(logic [31:0] a);
    for (int i = 0; i < 32; i++) if (a[i]) return i;
    return 32;
  endfunction

  function automatic int m_pop(logic [31:0] a);
    int c = 0;
    for (int i = 0; i < 32; i++) c += int'(a[i]);
    return c;
  endfunction

  function automatic logic [31:0] expect_of(logic [3:0] op, logic [31:0] a, logic [31:0] b, logic [4:0] s);
    logic [31:0] r;
    case (op)
      4'd0:  r = m_rol(a, int'(b % 32));
      4'd1:  r = m_ror(a, int'(b % 32));
      4'd2:  r = m_ror(a, int'(s));
      4'd3:  r = a & 32'h0000_FFFF;
      4'd4:  r = a[7]  ? (a | 32'hFFFF_FF00) : (a & 32'h0000_00FF);
      4'd5:  r = a[15] ? (a | 32'hFFFF_0000) : (a & 32'h0000_FFFF);
      4'd6:  r = m_clz(a);
      4'd7:  r = m_ctz(a);
      4'd8:  r = m_pop(a);
      4'd9:  r = {a[7:0], a[15:8], a[23:16], a[31:24]};
      4'd10: begin
        r = 0;
        for (int k = 0; k < 4; k++) if (((a >> (8*k)) & 32'hFF) != 0) r = r | (32'hFF << (8*k));
      end
      default: r = 0;
    endcase
    return r;
  endfunction

  task automatic apply_check(input string req, input logic [3:0] op, input logic [31:0] a,
                             input logic [31:0] b, input logic [4:0] s);
    logic [31:0] exp_r;
    logic        exp_ill;
    @(negedge clk);
    op_sel = op; src_a = a; src_b = b; shamt_imm = s;
    #1;
    exp_r   = expect_of(op, a, b, s);
    exp_ill = (op > 4'd10);
    n_checks++;
    if (result !== exp_r || op_illegal !== exp_ill) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%0d: got result=%h illegal=%b, expected result=%h illegal=%b",
               req, op, a, b, s, result, op_illegal, exp_r, exp_ill);
    end
  endtask

  localparam logic [31:0] PAT [8] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001, 32'h1234_5678,
                                      32'hDEAD_BEEF, 32'h0000_0080, 32'h0000_8000, 32'h00F0_0100};

  initial begin
    op_sel = 0; src_a = 0; src_b = 0; shamt_imm = 0;
    repeat (2) @(posedge clk);

    // Reset-like idle state: code 0 with zero operands yields zero, legal
    apply_check("R1", 4'd0, 32'h0, 32'h0, 5'd0);

    // R1: every rotate amount, garbage in src_b[31:5]
    for (int n = 0; n < 32; n++) begin
      apply_check("R1", 4'd0, 32'h8123_4567, {27'h5A5A5A5, 5'(n)}, 5'd0);
      apply_check("R1", 4'd1, 32'h8123_4567, {27'h7FFFFFF, 5'(n)}, 5'(31 - n));
      apply_check("R2", 4'd2, 32'hC001_D00D, 32'hFFFF_FFFF, 5'(n));
      apply_check("R2", 4'd2, 32'h0000_0003, 32'h0000_0007, 5'(n));
    end

    // R3..R8, R10 over patterns, with noisy src_b/shamt_imm
    for (int p = 0; p < 8; p++)
      for (int op = 3; op <= 10; op++)
        apply_check(op == 3 ? "R3" : op <= 5 ? "R4" : op <= 7 ? "R5" : op == 8 ? "R6" :
                    op == 9 ? "R7" : "R8", 4'(op), PAT[p], 32'hA5A5_A5A5 ^ (p * 32'h1111),
                    5'(p * 3));

    // R10: unary ops unaffected by src_b and shamt_imm
    for (int op = 3; op <= 10; op++) begin
      apply_check("R10", 4'(op), 32'h00FF_8070, 32'h0, 5'd0);
      apply_check("R10", 4'(op), 32'h00FF_8070, 32'hFFFF_FFFF, 5'd31);
    end

    // R5/R6: single-bit and low-mask sweeps
    for (int k = 0; k < 32; k++) begin
      apply_check("R5", 4'd6, 32'h1 << k, 32'h0, 5'd0);
      apply_check("R5", 4'd7, 32'h1 << k, 32'h0, 5'd0);
      apply_check("R6", 4'd8, (32'h1 << k) - 1, 32'h0, 5'd0);
      apply_check("R4", 4'd4, 32'h1 << k, 32'h0, 5'd0);
      apply_check("R4", 4'd5, 32'h1 << k, 32'h0, 5'd0);
      apply_check("R8", 4'd10, 32'h1 << k, 32'h0, 5'd0);
    end
    apply_check("R5", 4'd6, 32'h0, 32'hFFFF_FFFF, 5'd7);
    apply_check("R5", 4'd7, 32'h0, 32'hFFFF_FFFF, 5'd7);
    apply_check("R6", 4'd8, 32'hFFFF_FFFF, 32'h0, 5'd0);
    apply_check("R7", 4'd9, 32'h0102_0304, 32'h0, 5'd0);

    // R9: unsupported codes
    for (int op = 11; op < 16; op++) begin
      apply_check("R9", 4'(op), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31);
      apply_check("R9", 4'(op), 32'h1234_5678, 32'h3, 5'd1);
    end

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule